// File: doc/BRIEF.md
# Per-Destination Acknowledge Tracker

This block follows a single edge-triggered interrupt line that can fan out to several destinations. Each destination that accepts a delivery owes one end-of-interrupt (EOI). The block keeps one "owed" bit per destination and a count of the bits that are set. While any acknowledgement is still owed, a new assertion of the line is not forwarded. Instead it is reported as coalesced in the same cycle, so upstream logic can tell that the edge was merged into the one already in flight.

The delivery fabric and destination matching sit outside the block. When an assertion is accepted, the fabric supplies the set of destinations it actually reached, and that set becomes the owed map. EOIs arrive as a per-destination vector and may overlap in one cycle. A clear command empties the tracker. A resync command brings the owed bits of the currently matching destinations into line with their reported pending state. An EOI seen while nothing is owed is an underflow attempt. The block flags it and rebuilds the map from the destination states.

Top module: `ack_tracker`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, owed_o and owed_cnt_o are zero. coalesced_o is low whenever fire_i is low.
- R2: When fire_i is high, owed_cnt_o is zero, and neither clear_i nor resync_i is high, owed_o equals that cycle's reach_i from the next cycle on. owed_cnt_o equals its number of set bits.
- R3: When fire_i is high while owed_cnt_o is nonzero, coalesced_o is high in that same cycle. No destination bit becomes newly set in the next cycle.
- R4: With owed_cnt_o nonzero and neither clear_i nor resync_i high, each destination whose eoi_i bit is high has its owed bit cleared in the next cycle. An eoi_i bit on a destination that is not owed changes nothing.
- R5: clear_i empties owed_o and owed_cnt_o in the next cycle. It overrides every other input in that cycle.
- R6: resync_i, when clear_i is low, sets each owed bit whose match_i bit is high to that destination's pend_i bit. Bits whose match_i bit is low keep their value. resync_i takes priority over fire_i and eoi_i.
- R7: underflow_o is high in any cycle where some eoi_i bit is high while owed_cnt_o is zero. If fire_i, clear_i and resync_i are all low in that cycle, the next owed_o is match_i AND pend_i.
- R8: owed_cnt_o always equals the population count of owed_o.
- R9: An accepted assertion whose reach_i is all zeros (a failed delivery) leaves owed_cnt_o at zero. The next assertion is therefore not coalesced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | 1 | New assertion of the tracked line |
| reach_i | input | N_DEST | Destinations reached by the delivery made this cycle |
| eoi_i | input | N_DEST | Per-destination end-of-interrupt events |
| clear_i | input | 1 | Empty the tracker |
| resync_i | input | 1 | Realign owed bits of matching destinations |
| match_i | input | N_DEST | Destinations currently addressed by the line |
| pend_i | input | N_DEST | Per-destination pending-EOI state |
| owed_o | output | N_DEST | Destinations still owing an EOI |
| owed_cnt_o | output | $clog2(N_DEST+1) | Number of owed destinations |
| coalesced_o | output | 1 | fire_i was merged into an outstanding delivery |
| underflow_o | output | 1 | EOI arrived while nothing was owed |

## Verification
On every cycle, the assertions check the following: the count agrees with the map, a coalesced edge never sets a new bit, an accepted delivery loads reach_i exactly, EOIs only remove bits, a clear empties the map, a resync aligns the matched bits, and an underflow raises the flag and rebuilds the map. What only the bench scenarios can show is how these combine. That covers a failed delivery followed by a fresh one, several EOIs in one cycle including some on destinations that owe nothing, a clear arriving alongside an assertion, a resync that leaves unmatched bits alone, and long mixed sequences compared against a behavioural model.

// File: rtl/ack_tracker.sv
module ack_tracker #(
  parameter int N_DEST = 8,
  localparam int CW = $clog2(N_DEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [N_DEST-1:0] reach_i,
  input  logic [N_DEST-1:0] eoi_i,
  input  logic              clear_i,
  input  logic              resync_i,
  input  logic [N_DEST-1:0] match_i,
  input  logic [N_DEST-1:0] pend_i,
  output logic [N_DEST-1:0] owed_o,
  output logic [CW-1:0]     owed_cnt_o,
  output logic              coalesced_o,
  output logic              underflow_o
);

  logic              idle;
  logic [N_DEST-1:0] owed_nxt;
  logic [CW-1:0]     cnt_nxt;

  assign idle        = (owed_cnt_o == '0);
  assign coalesced_o = fire_i & ~idle;
  assign underflow_o = (|eoi_i) & idle;

  always_comb begin
    if (clear_i)
      owed_nxt = '0;
    else if (resync_i)
      owed_nxt = (owed_o & ~match_i) | (match_i & pend_i);
    else if (idle) begin
      if (fire_i)
        owed_nxt = reach_i;
      else if (underflow_o)
        owed_nxt = match_i & pend_i;
      else
        owed_nxt = owed_o;
    end else
      owed_nxt = owed_o & ~eoi_i;
  end

  always_comb begin
    cnt_nxt = '0;
    for (int d = 0; d < N_DEST; d++)
      cnt_nxt = cnt_nxt + CW'(owed_nxt[d]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_o     <= '0;
      owed_cnt_o <= '0;
    end else begin
      owed_o     <= owed_nxt;
      owed_cnt_o <= cnt_nxt;
    end
  end

endmodule

module ack_tracker_chk #(
  parameter int N_DEST = 8,
  localparam int CW = $clog2(N_DEST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire_i,
  input logic [N_DEST-1:0] reach_i,
  input logic [N_DEST-1:0] eoi_i,
  input logic              clear_i,
  input logic              resync_i,
  input logic [N_DEST-1:0] match_i,
  input logic [N_DEST-1:0] pend_i,
  input logic [N_DEST-1:0] owed_o,
  input logic [CW-1:0]     owed_cnt_o,
  input logic              coalesced_o,
  input logic              underflow_o
);

  // R8
  cnt_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt_o == CW'($countones(owed_o)));

  // R1
  no_spurious_coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |-> !coalesced_o);

  // R3
  coalesce_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && owed_cnt_o != '0) |-> coalesced_o);

  // R3
  coalesce_no_new_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && owed_cnt_o != '0 && !clear_i && !resync_i)
      |=> ((owed_o & ~$past(owed_o)) == '0));

  // R2
  delivery_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && owed_cnt_o == '0 && !clear_i && !resync_i)
      |=> (owed_o == $past(reach_i)));

  // R4
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_cnt_o != '0 && !clear_i && !resync_i)
      |=> (owed_o == ($past(owed_o) & ~$past(eoi_i))));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (owed_o == '0 && owed_cnt_o == '0));

  // R6
  resync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_i && !clear_i)
      |=> (((owed_o ^ $past(pend_i)) & $past(match_i)) == '0 &&
           ((owed_o ^ $past(owed_o)) & ~$past(match_i)) == '0));

  // R7
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eoi_i) && owed_cnt_o == '0) |-> underflow_o);

  // R7
  underflow_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !fire_i && !clear_i && !resync_i)
      |=> (owed_o == ($past(match_i) & $past(pend_i))));

endmodule

bind ack_tracker ack_tracker_chk #(.N_DEST(N_DEST)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .reach_i(reach_i),
  .eoi_i(eoi_i), .clear_i(clear_i), .resync_i(resync_i),
  .match_i(match_i), .pend_i(pend_i), .owed_o(owed_o),
  .owed_cnt_o(owed_cnt_o), .coalesced_o(coalesced_o),
  .underflow_o(underflow_o)
);

// File: tb/ack_tracker_tb.sv
`timescale 1ns/1ps
module ack_tracker_tb;
  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic fire = 0, clr = 0, rsy = 0;
  logic [N-1:0] reach = '0, eoi = '0, match = '0, pend = '0;
  logic [N-1:0] owed;
  logic [3:0]   cnt;
  logic         coal, unf;

  int total = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] ref_map;

  always #4 clk = ~clk;

  ack_tracker #(.N_DEST(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .reach_i(reach), .eoi_i(eoi),
    .clear_i(clr), .resync_i(rsy), .match_i(match), .pend_i(pend),
    .owed_o(owed), .owed_cnt_o(cnt), .coalesced_o(coal), .underflow_o(unf)
  );

  function automatic int pop(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic logic [N-1:0] model_step(input logic [N-1:0] m);
    logic [N-1:0] r = m;
    int owed_n = pop(m);
    if (clr) return '0;
    if (rsy) begin
      for (int i = 0; i < N; i++) if (match[i]) r[i] = pend[i];
      return r;
    end
    if (owed_n == 0) begin
      if (fire) return reach;
      if (eoi != 0) begin
        for (int i = 0; i < N; i++) r[i] = match[i] && pend[i];
        return r;
      end
      return m;
    end
    for (int i = 0; i < N; i++) if (eoi[i] && r[i]) r[i] = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ref_map <= '0;
    else        ref_map <= model_step(ref_map);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic f, input logic [N-1:0] rc,
                     input logic [N-1:0] e, input logic c, input logic rs,
                     input logic [N-1:0] mt, input logic [N-1:0] pd);
    @(negedge clk);
    chk(req, "owed map", owed, ref_map);
    chk("R8", "owed count", cnt, pop(ref_map));
    fire = f; reach = rc; eoi = e; clr = c; rsy = rs; match = mt; pend = pd;
    #1;
    chk(req, "coalesced", coal, (f && pop(ref_map) > 0));
    chk(req, "underflow", unf, (e != 0 && pop(ref_map) == 0));
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset map", owed, 0);
    chk("R1", "reset count", cnt, 0);
    rst_n = 1;
    cyc("R1", 0, 0, 0, 0, 0, 0, 0);
    // R2 delivery to four destinations
    cyc("R2", 1, 8'b1011_0010, 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0, 0);
    // R3 coalesced edge with a different reach
    cyc("R3", 1, 8'b0100_0001, 0, 0, 0, 0, 0);
    // R4 EOI on non-owed bit 0, then two EOIs at once
    cyc("R4", 0, 0, 8'b0000_0001, 0, 0, 0, 0);
    cyc("R4", 0, 0, 8'b1001_0000, 0, 0, 0, 0);
    cyc("R4", 0, 0, 8'b0010_0010, 0, 0, 0, 0);
    // R9 failed delivery, then a fresh one is not coalesced
    cyc("R9", 1, 8'h00, 0, 0, 0, 0, 0);
    cyc("R9", 1, 8'hFF, 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0, 0);
    // R5 clear with a simultaneous assertion and EOI
    cyc("R5", 1, 8'h0F, 8'h01, 1, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 0);
    // R6 resync touching only matched destinations
    cyc("R2", 1, 8'hF0, 0, 0, 0, 0, 0);
    cyc("R6", 1, 8'h0F, 8'h10, 0, 1, 8'h3C, 8'h05);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 1, 0, 0, 0);
    // R7 underflow with rebuild, then underflow during an accepted edge
    cyc("R7", 0, 0, 8'h02, 0, 0, 8'hFF, 8'h81);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 1, 0, 0, 0);
    cyc("R7", 1, 8'h22, 8'h40, 0, 0, 8'hFF, 8'hFF);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0);
    // mixed sequence against the model
    for (int k = 0; k < 400; k++) begin
      logic [7:0] sel = 8'($urandom);
      cyc("R8", sel[0], 8'($urandom), (sel[3:1] == 0) ? 8'($urandom) : 8'h00,
          sel[7:4] == 0, sel[7:4] == 1, 8'($urandom), 8'($urandom));
    end
    cyc("R8", 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule